// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the purely combinational control unit of a single-cycle processor core that executes a small instruction subset. It covers register-to-register arithmetic and logic, word load, word store, branch-if-equal and unconditional jump. It looks at the 6-bit primary opcode of the fetched instruction. From it, the block drives every multiplexer select and write strobe the datapath needs during that one cycle. It also drives a 2-bit ALU operation class and a flag for opcodes outside the subset.

The ALU operation is decoded in two levels. The first level, the opcode decoder, sorts the instruction into one of three classes:
- a fixed add, for address formation;
- a fixed subtract, for the equality compare;
- "consult the function field".

The second level, the ALU-control stage, reads the 6-bit function field only in that third class. It turns the field into a 4-bit operation code for the ALU. The integrating core combines `branch_o` with the ALU zero result to steer the program counter.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: Opcode 0x00 (register type) gives dst_sel_rd_o=1, src_sel_imm_o=0, wb_sel_mem_o=0, reg_we_o=1, mem_re_o=0, mem_we_o=0, branch_o=0, jump_o=0, illegal_o=0 and alu_class_o=2'b10.
- R2: Opcode 0x23 (load) gives dst_sel_rd_o=0, src_sel_imm_o=1, wb_sel_mem_o=1, reg_we_o=1, mem_re_o=1, mem_we_o=0, branch_o=0, jump_o=0, illegal_o=0 and alu_class_o=2'b00.
- R3: Opcode 0x2B (store) gives src_sel_imm_o=1 and mem_we_o=1. It gives alu_class_o=2'b00. Every other control output is 0.
- R4: Opcode 0x04 (branch-if-equal) gives branch_o=1 and alu_class_o=2'b01. Every other control output is 0, so the second ALU operand is the register.
- R5: Opcode 0x02 (jump) gives jump_o=1 and alu_class_o=2'b00. Every other control output is 0.
- R6: Any other opcode gives illegal_o=1 and alu_class_o=2'b00. Every select and strobe is 0.
- R7: With class 2'b00, alu_ctl_o is 4'b0010 (add) whatever the function field holds.
- R8: With class 2'b01, alu_ctl_o is 4'b0110 (subtract) whatever the function field holds.
- R9: With class 2'b10, the function field maps to the ALU code as follows: 0x20→4'b0010 add, 0x22→4'b0110 subtract, 0x24→4'b0000 AND, 0x25→4'b0001 OR, 0x2A→4'b0111 set-less-than.
- R10: With class 2'b10 and any other function value, alu_ctl_o falls back to 4'b0010 (add).
- R11: All six function bits are compared. A value that matches a listed code only in its low bits (for example 0x02, 0x12 or 0x0A) is an unlisted value and is handled as in R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Primary opcode field of the instruction |
| funct_i | input | 6 | Function field of the instruction |
| dst_sel_rd_o | output | 1 | 1: destination register from rd field, 0: from rt field |
| src_sel_imm_o | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_sel_mem_o | output | 1 | 1: write-back data comes from memory read data |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read strobe |
| mem_we_o | output | 1 | Data memory write strobe |
| branch_o | output | 1 | Instruction is a conditional branch on equality |
| jump_o | output | 1 | Instruction is an unconditional jump |
| alu_class_o | output | 2 | First-level ALU operation class |
| alu_ctl_o | output | 4 | Second-level ALU operation code |
| illegal_o | output | 1 | Opcode is outside the supported subset |

## Verification
The bench sweeps all 64 opcodes. A decoder that matched opcodes on too few bits would then raise a store or branch strobe on some neighbouring illegal code, or miss the illegal flag there. Load and branch are driven with function fields that happen to be valid arithmetic codes. A second level that read the function field outside class 2'b10 would then return AND or OR instead of add or subtract. Function values that share their low bits with a listed code, such as 0x12 and 0x0A, test the full six-bit compare: a decoder that looked only at the low bits would return subtract or set-less-than instead of the add fallback.

// File: rtl/insn_ctrl_pkg.sv
package insn_ctrl_pkg;

    localparam int OPC_W  = 6;
    localparam int FN_W   = 6;
    localparam int ALUC_W = 4;
    localparam int CLS_W  = 2;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    // first-level ALU class
    typedef enum logic [CLS_W-1:0] {
        CLS_ADDR = 2'b00,
        CLS_CMP  = 2'b01,
        CLS_FUNC = 2'b10,
        CLS_RSV  = 2'b11
    } alu_class_e;

    // second-level ALU operation code
    typedef enum logic [ALUC_W-1:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    // instruction kind found by the opcode classifier
    typedef enum logic [2:0] {
        KIND_REG,
        KIND_LOAD,
        KIND_STORE,
        KIND_BEQ,
        KIND_JUMP,
        KIND_BAD
    } insn_kind_e;

    typedef struct packed {
        logic       dst_rd;
        logic       src_imm;
        logic       wb_mem;
        logic       reg_we;
        logic       mem_re;
        logic       mem_we;
        logic       branch;
        logic       jump;
        logic       illegal;
        alu_class_e cls;
    } main_ctl_t;

    // every select and strobe low, class address-add
    function automatic main_ctl_t ctl_quiet();
        main_ctl_t c;
        c.dst_rd  = 1'b0;
        c.src_imm = 1'b0;
        c.wb_mem  = 1'b0;
        c.reg_we  = 1'b0;
        c.mem_re  = 1'b0;
        c.mem_we  = 1'b0;
        c.branch  = 1'b0;
        c.jump    = 1'b0;
        c.illegal = 1'b0;
        c.cls     = CLS_ADDR;
        return c;
    endfunction

    // function-field decode; unlisted values fall back to add
    function automatic alu_op_e fn_to_op(input logic [FN_W-1:0] fn);
        alu_op_e op;
        case (fn)
            FN_ADD:  op = ALU_ADD;
            FN_SUB:  op = ALU_SUB;
            FN_AND:  op = ALU_AND;
            FN_OR:   op = ALU_OR;
            FN_SLT:  op = ALU_SLT;
            default: op = ALU_ADD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/insn_opcode_classifier.sv
module insn_opcode_classifier
    import insn_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output insn_kind_e       kind_o
);
    always_comb begin
        case (opcode_i)
            OPC_REG:   kind_o = KIND_REG;
            OPC_LOAD:  kind_o = KIND_LOAD;
            OPC_STORE: kind_o = KIND_STORE;
            OPC_BEQ:   kind_o = KIND_BEQ;
            OPC_JUMP:  kind_o = KIND_JUMP;
            default:   kind_o = KIND_BAD;
        endcase
    end
endmodule

// File: rtl/insn_main_table.sv
module insn_main_table
    import insn_ctrl_pkg::*;
(
    input  insn_kind_e kind_i,
    output main_ctl_t  ctl_o
);
    always_comb begin
        ctl_o = ctl_quiet();
        case (kind_i)
            KIND_REG: begin
                ctl_o.dst_rd = 1'b1;
                ctl_o.reg_we = 1'b1;
                ctl_o.cls    = CLS_FUNC;
            end
            KIND_LOAD: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.wb_mem  = 1'b1;
                ctl_o.reg_we  = 1'b1;
                ctl_o.mem_re  = 1'b1;
            end
            KIND_STORE: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.mem_we  = 1'b1;
            end
            KIND_BEQ: begin
                ctl_o.branch = 1'b1;
                ctl_o.cls    = CLS_CMP;
            end
            KIND_JUMP: begin
                ctl_o.jump = 1'b1;
            end
            default: begin
                ctl_o.illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/insn_alu_control.sv
module insn_alu_control
    import insn_ctrl_pkg::*;
(
    input  alu_class_e      cls_i,
    input  logic [FN_W-1:0] funct_i,
    output alu_op_e         op_o
);
    always_comb begin
        case (cls_i)
            CLS_ADDR: op_o = ALU_ADD;
            CLS_CMP:  op_o = ALU_SUB;
            CLS_FUNC: op_o = fn_to_op(funct_i);
            default:  op_o = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
    import insn_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [FN_W-1:0]   funct_i,
    output logic              dst_sel_rd_o,
    output logic              src_sel_imm_o,
    output logic              wb_sel_mem_o,
    output logic              reg_we_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic              branch_o,
    output logic              jump_o,
    output logic [CLS_W-1:0]  alu_class_o,
    output logic [ALUC_W-1:0] alu_ctl_o,
    output logic              illegal_o
);
    insn_kind_e kind;
    main_ctl_t  ctl;
    alu_op_e    op;

    insn_opcode_classifier u_cls (
        .opcode_i (opcode_i),
        .kind_o   (kind)
    );

    insn_main_table u_main (
        .kind_i (kind),
        .ctl_o  (ctl)
    );

    insn_alu_control u_aluc (
        .cls_i   (ctl.cls),
        .funct_i (funct_i),
        .op_o    (op)
    );

    assign dst_sel_rd_o  = ctl.dst_rd;
    assign src_sel_imm_o = ctl.src_imm;
    assign wb_sel_mem_o  = ctl.wb_mem;
    assign reg_we_o      = ctl.reg_we;
    assign mem_re_o      = ctl.mem_re;
    assign mem_we_o      = ctl.mem_we;
    assign branch_o      = ctl.branch;
    assign jump_o        = ctl.jump;
    assign illegal_o     = ctl.illegal;
    assign alu_class_o   = ctl.cls;
    assign alu_ctl_o     = op;
endmodule

// File: rtl/insn_ctrl_decoder_chk.sv
module insn_ctrl_decoder_chk (
    input logic       dst_sel_rd_o,
    input logic       src_sel_imm_o,
    input logic       wb_sel_mem_o,
    input logic       reg_we_o,
    input logic       mem_re_o,
    input logic       mem_we_o,
    input logic       branch_o,
    input logic       jump_o,
    input logic [1:0] alu_class_o,
    input logic [3:0] alu_ctl_o,
    input logic       illegal_o
);
    always_comb begin
        if (alu_class_o == 2'b00)
            p_addr_class_add_r7: assert (alu_ctl_o == 4'b0010)
                else $error("class 00 without add");
        if (alu_class_o == 2'b01)
            p_cmp_class_sub_r8: assert (alu_ctl_o == 4'b0110)
                else $error("class 01 without subtract");
        if (illegal_o)
            p_illegal_quiet_r6: assert (!(reg_we_o || mem_re_o || mem_we_o || branch_o || jump_o))
                else $error("strobe active on illegal opcode");
        p_strobe_excl_r5: assert ($onehot0({mem_re_o, mem_we_o, branch_o, jump_o}))
            else $error("more than one exclusive strobe");
        if (mem_re_o)
            p_load_path_r2: assert (wb_sel_mem_o && reg_we_o && src_sel_imm_o)
                else $error("load without memory write-back path");
        if (mem_we_o)
            p_store_nowrite_r3: assert (!reg_we_o && src_sel_imm_o)
                else $error("store writes register or uses register operand");
        if (alu_class_o == 2'b10)
            p_func_class_rd_r1: assert (dst_sel_rd_o && reg_we_o && !src_sel_imm_o)
                else $error("function class without register-type controls");
        if (branch_o)
            p_branch_cmp_r4: assert (alu_class_o == 2'b01 && !src_sel_imm_o)
                else $error("branch without compare class");
    end
endmodule

bind insn_ctrl_decoder insn_ctrl_decoder_chk chk_i (
    .dst_sel_rd_o  (dst_sel_rd_o),
    .src_sel_imm_o (src_sel_imm_o),
    .wb_sel_mem_o  (wb_sel_mem_o),
    .reg_we_o      (reg_we_o),
    .mem_re_o      (mem_re_o),
    .mem_we_o      (mem_we_o),
    .branch_o      (branch_o),
    .jump_o        (jump_o),
    .alu_class_o   (alu_class_o),
    .alu_ctl_o     (alu_ctl_o),
    .illegal_o     (illegal_o)
);

// File: tb/insn_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module insn_ctrl_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opc = 6'h00;
    logic [5:0] fn  = 6'h20;

    logic       dst, src, wb, rwe, mre, mwe, br, jmp, ill;
    logic [1:0] cls;
    logic [3:0] aluc;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    insn_ctrl_decoder dut_i (
        .opcode_i      (opc),
        .funct_i       (fn),
        .dst_sel_rd_o  (dst),
        .src_sel_imm_o (src),
        .wb_sel_mem_o  (wb),
        .reg_we_o      (rwe),
        .mem_re_o      (mre),
        .mem_we_o      (mwe),
        .branch_o      (br),
        .jump_o        (jmp),
        .alu_class_o   (cls),
        .alu_ctl_o     (aluc),
        .illegal_o     (ill)
    );

    // bench-side function-field table (R9, R10, R11)
    function automatic logic [3:0] exp_fn(input logic [5:0] f);
        if (f == 6'h20) return 4'b0010;
        if (f == 6'h22) return 4'b0110;
        if (f == 6'h24) return 4'b0000;
        if (f == 6'h25) return 4'b0001;
        if (f == 6'h2A) return 4'b0111;
        return 4'b0010;
    endfunction

    // vector: dst src wb rwe mre mwe br jmp ill cls[1:0] aluc[3:0]
    function automatic logic [14:0] pack(input logic d, s, w, r, mr, mw, b, j, i,
                                         input logic [1:0] c, input logic [3:0] a);
        return {d, s, w, r, mr, mw, b, j, i, c, a};
    endfunction

    task automatic apply_check(input logic [5:0] o, input logic [5:0] f,
                               input logic [14:0] exp, input string tag);
        @(negedge clk);
        opc = o;
        fn  = f;
        #1;
        checks++;
        if ({dst, src, wb, rwe, mre, mwe, br, jmp, ill, cls, aluc} !== exp) begin
            failures++;
            $display("FAIL %s opc=%h fn=%h actual=%b expected=%b", tag, o, f,
                     {dst, src, wb, rwe, mre, mwe, br, jmp, ill, cls, aluc}, exp);
        end
    endtask

    task automatic t_reset_state();
        // inputs held at a register-type add through reset (R1)
        checks++;
        if ({dst, rwe, ill, cls, aluc} !== {1'b1, 1'b1, 1'b0, 2'b10, 4'b0010}) begin
            failures++;
            $display("FAIL R1 reset state actual=%b expected=%b",
                     {dst, rwe, ill, cls, aluc}, {1'b1, 1'b1, 1'b0, 2'b10, 4'b0010});
        end
    endtask

    task automatic t_regtype();
        logic [5:0] fl [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        foreach (fl[k])
            apply_check(6'h00, fl[k], pack(1,0,0,1,0,0,0,0,0,2'b10, exp_fn(fl[k])), "R1/R9 reg-type");
    endtask

    task automatic t_load();
        apply_check(6'h23, 6'h24, pack(0,1,1,1,1,0,0,0,0,2'b00,4'b0010), "R2/R7 load fn=and");
        apply_check(6'h23, 6'h2A, pack(0,1,1,1,1,0,0,0,0,2'b00,4'b0010), "R2/R7 load fn=slt");
    endtask

    task automatic t_store();
        apply_check(6'h2B, 6'h25, pack(0,1,0,0,0,1,0,0,0,2'b00,4'b0010), "R3/R7 store fn=or");
        apply_check(6'h2B, 6'h3F, pack(0,1,0,0,0,1,0,0,0,2'b00,4'b0010), "R3/R7 store fn=3f");
    endtask

    task automatic t_branch();
        apply_check(6'h04, 6'h24, pack(0,0,0,0,0,0,1,0,0,2'b01,4'b0110), "R4/R8 beq fn=and");
        apply_check(6'h04, 6'h20, pack(0,0,0,0,0,0,1,0,0,2'b01,4'b0110), "R4/R8 beq fn=add");
    endtask

    task automatic t_jump();
        apply_check(6'h02, 6'h2A, pack(0,0,0,0,0,0,0,1,0,2'b00,4'b0010), "R5 jump");
    endtask

    task automatic t_illegal_sweep();
        for (int o = 0; o < 64; o++) begin
            if (o == 'h00 || o == 'h23 || o == 'h2B || o == 'h04 || o == 'h02) continue;
            apply_check(o[5:0], 6'h24, pack(0,0,0,0,0,0,0,0,1,2'b00,4'b0010), "R6 illegal opcode");
        end
    endtask

    task automatic t_unlisted_funct();
        apply_check(6'h00, 6'h26, pack(1,0,0,1,0,0,0,0,0,2'b10,4'b0010), "R10 fn=26");
        apply_check(6'h00, 6'h00, pack(1,0,0,1,0,0,0,0,0,2'b10,4'b0010), "R10 fn=00");
    endtask

    task automatic t_full_width_funct();
        apply_check(6'h00, 6'h02, pack(1,0,0,1,0,0,0,0,0,2'b10,4'b0010), "R11 fn=02");
        apply_check(6'h00, 6'h12, pack(1,0,0,1,0,0,0,0,0,2'b10,4'b0010), "R11 fn=12");
        apply_check(6'h00, 6'h0A, pack(1,0,0,1,0,0,0,0,0,2'b10,4'b0010), "R11 fn=0a");
        apply_check(6'h00, 6'h05, pack(1,0,0,1,0,0,0,0,0,2'b10,4'b0010), "R11 fn=05");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state();
        t_regtype();
        t_load();
        t_store();
        t_branch();
        t_jump();
        t_illegal_sweep();
        t_unlisted_funct();
        t_full_width_funct();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule